// File: doc/BRIEF.md
# Fence-aware memory access sequencer

This block sits between an in-order stream of decoded memory operations and a single memory request/response port. Each operation arrives on a valid/ready handshake with a 3-bit opcode, an address, write data and a 4-bit tag. Operations wait in an 8-entry program-order queue. Loads go straight to memory from the head of that queue. Stores move into a 4-entry store buffer, which writes them out in order with one write in flight at a time. A load may therefore overtake older buffered stores, and a store may be written while older loads are still outstanding.

Three fence kinds and a serialize marker retire from the head of the queue as soon as their own condition holds. None of them sends a memory request. Each retiring operation raises a one-cycle done pulse with its tag. A retiring load also returns its data on that pulse. While a serialize marker is pending, the block refuses new operations and holds its busy output high. It releases intake once every older load and store has its response and the store buffer is empty.

Top module: `fence_seq`

## Requirements
- R1: After reset the block has inReady high, busy low, doneValid low and memReqValid low.
- R2: A load (opcode 0) issues a read request with its address and tag. It retires on the read response with doneValid high, its tag and the response data. Several reads may be outstanding at once, up to MAX_LOADS.
- R3: Stores (opcode 1) are written to memory in program order, with at most one write outstanding. Each store retires on its write response, with its tag on the done port.
- R4: A load whose address matches no buffered or in-flight store issues before older stores that are still in the store buffer. It has priority on the request port.
- R5: A load whose address matches a buffered or in-flight store is not requested until that store's write response has arrived. It then returns the stored data.
- R6: A load fence (opcode 2) retires only once no read is outstanding. Loads behind it are not requested before every older load has its response.
- R7: A store fence (opcode 3) retires when it reaches the head of the queue, without waiting for older writes. In-order writing already orders the stores around it, and a load behind it may complete before an older store.
- R8: A full fence (opcode 4) retires only once no read is outstanding, the store buffer is empty and no write is outstanding. Loads behind it are not requested before then, but intake stays open while it waits.
- R9: From acceptance of a serialize marker (opcode 5) until it retires, busy is high and inReady is low. It retires under the same condition as a full fence, after which later operations are requested.
- R10: Fences, serialize markers and opcodes 6 and 7 (no-op) retire with a done pulse carrying their tag and never create a memory request. A memory response takes the done port in its cycle, and such a retirement then moves to a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | An operation is offered |
| inReady | output | 1 | Operation accepted on this edge when inValid is high |
| inOp | input | 3 | Opcode: 0 load, 1 store, 2 load fence, 3 store fence, 4 full fence, 5 serialize, 6/7 no-op |
| inAddr | input | ADDR_W | Memory address |
| inData | input | DATA_W | Store data |
| inTag | input | TAG_W | Tag returned on retirement |
| memReqValid | output | 1 | Memory request offered |
| memReqReady | input | 1 | Memory accepts the request on this edge |
| memReqWrite | output | 1 | 1 for a write, 0 for a read |
| memReqAddr | output | ADDR_W | Request address |
| memReqData | output | DATA_W | Write data |
| memReqTag | output | TAG_W | Request tag, echoed in the response |
| memRspValid | input | 1 | Response present this cycle |
| memRspWrite | input | 1 | Response belongs to a write |
| memRspTag | input | TAG_W | Tag of the completed request |
| memRspData | input | DATA_W | Read data |
| doneValid | output | 1 | An operation retires this cycle |
| doneTag | output | TAG_W | Tag of the retiring operation |
| doneData | output | DATA_W | Read data for a retiring load, else zero |
| busy | output | 1 | A serialize marker is pending |

## Verification
The bench uses a memory model whose latency depends on the address: slow for addresses 8 to 15 and fast below that. This lets it order completions on purpose. A slow store followed by a fast load to a different address shows whether loads overtake stores. The same pair with one shared address shows whether the forwarding hazard is held off, and it returns the new data. A slow load followed by a load fence and a fast load, or a slow store followed by a store fence, a full fence or a serialize marker and then a fast load, sets each barrier's rule apart from the others: only the store fence lets the load finish first. A run of six slow stores fills the buffer and tests write ordering. Two slow loads show reads overlapping.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  localparam logic [2:0] OP_LOAD   = 3'd0;
  localparam logic [2:0] OP_STORE  = 3'd1;
  localparam logic [2:0] OP_LFENCE = 3'd2;
  localparam logic [2:0] OP_SFENCE = 3'd3;
  localparam logic [2:0] OP_FULL   = 3'd4;
  localparam logic [2:0] OP_SERIAL = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic qPush;      // write incoming op into the program-order queue
    logic qPop;       // head of queue leaves
    logic sbPush;     // head store moves into the store buffer
    logic sbPop;      // oldest buffered store goes to memory
    logic selStore;   // request port carries the store buffer head
    logic retireHead; // non-memory head entry retires now
  } fseqStrb_t;

endpackage

// File: rtl/fseq_datapath.sv
module fseq_datapath
  import fseq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4,
  parameter int Q_DEPTH  = 8,
  parameter int SB_DEPTH = 4,
  localparam int QPTR_W  = $clog2(Q_DEPTH),
  localparam int QCNT_W  = $clog2(Q_DEPTH + 1),
  localparam int SBPTR_W = $clog2(SB_DEPTH),
  localparam int SBCNT_W = $clog2(SB_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  fseqStrb_t         strb,
  input  logic [2:0]        inOp,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  input  logic [TAG_W-1:0]  inTag,
  input  logic              flightValid,
  input  logic              memRspValid,
  input  logic              memRspWrite,
  input  logic [TAG_W-1:0]  memRspTag,
  input  logic [DATA_W-1:0] memRspData,
  output logic [QCNT_W-1:0] qCount,
  output logic [SBCNT_W-1:0] sbCount,
  output logic [2:0]        headOp,
  output logic              matchHit,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqData,
  output logic [TAG_W-1:0]  memReqTag,
  output logic              doneValid,
  output logic [TAG_W-1:0]  doneTag,
  output logic [DATA_W-1:0] doneData
);

  function automatic logic [QPTR_W-1:0] qNext(input logic [QPTR_W-1:0] p);
    return (p == QPTR_W'(Q_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [SBPTR_W-1:0] sbNext(input logic [SBPTR_W-1:0] p);
    return (p == SBPTR_W'(SB_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // program-order queue
  logic [2:0]        qOp   [Q_DEPTH];
  logic [ADDR_W-1:0] qAddr [Q_DEPTH];
  logic [DATA_W-1:0] qData [Q_DEPTH];
  logic [TAG_W-1:0]  qTag  [Q_DEPTH];
  logic [QPTR_W-1:0] qWr, qRd;
  logic [QCNT_W-1:0] qCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      qWr  <= '0;
      qRd  <= '0;
      qCnt <= '0;
    end else begin
      if (strb.qPush) begin
        qOp[qWr]   <= inOp;
        qAddr[qWr] <= inAddr;
        qData[qWr] <= inData;
        qTag[qWr]  <= inTag;
        qWr        <= qNext(qWr);
      end
      if (strb.qPop) qRd <= qNext(qRd);
      case ({strb.qPush, strb.qPop})
        2'b10:   qCnt <= qCnt + 1'b1;
        2'b01:   qCnt <= qCnt - 1'b1;
        default: ;
      endcase
    end
  end

  logic [ADDR_W-1:0] headAddr;
  logic [TAG_W-1:0]  headTag;
  assign qCount   = qCnt;
  assign headOp   = qOp[qRd];
  assign headAddr = qAddr[qRd];
  assign headTag  = qTag[qRd];

  // store buffer
  logic [ADDR_W-1:0]  sbAddr [SB_DEPTH];
  logic [DATA_W-1:0]  sbData [SB_DEPTH];
  logic [TAG_W-1:0]   sbTag  [SB_DEPTH];
  logic [SB_DEPTH-1:0] sbVld;
  logic [SBPTR_W-1:0] sbWr, sbRd;
  logic [SBCNT_W-1:0] sbCnt;
  logic [ADDR_W-1:0]  flightAddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sbWr  <= '0;
      sbRd  <= '0;
      sbCnt <= '0;
      sbVld <= '0;
    end else begin
      if (strb.sbPush) begin
        sbAddr[sbWr] <= headAddr;
        sbData[sbWr] <= qData[qRd];
        sbTag[sbWr]  <= headTag;
        sbVld[sbWr]  <= 1'b1;
        sbWr         <= sbNext(sbWr);
      end
      if (strb.sbPop) begin
        sbVld[sbRd] <= 1'b0;
        sbRd        <= sbNext(sbRd);
      end
      case ({strb.sbPush, strb.sbPop})
        2'b10:   sbCnt <= sbCnt + 1'b1;
        2'b01:   sbCnt <= sbCnt - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (strb.sbPop) flightAddr <= sbAddr[sbRd];
  end

  assign sbCount = sbCnt;

  // address hazard between head load and any store not yet written
  logic [SB_DEPTH-1:0] hitVec;
  for (genvar i = 0; i < SB_DEPTH; i++) begin : gHit
    assign hitVec[i] = sbVld[i] && (sbAddr[i] == headAddr);
  end
  assign matchHit = (|hitVec) || (flightValid && (flightAddr == headAddr));

  // request port fields
  assign memReqAddr = strb.selStore ? sbAddr[sbRd] : headAddr;
  assign memReqData = strb.selStore ? sbData[sbRd] : '0;
  assign memReqTag  = strb.selStore ? sbTag[sbRd]  : headTag;

  // retirement port
  assign doneValid = memRspValid || strb.retireHead;
  assign doneTag   = memRspValid ? memRspTag : headTag;
  assign doneData  = (memRspValid && !memRspWrite) ? memRspData : '0;

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int Q_DEPTH   = 8,
  parameter int SB_DEPTH  = 4,
  parameter int MAX_LOADS = 4,
  localparam int QCNT_W  = $clog2(Q_DEPTH + 1),
  localparam int SBCNT_W = $clog2(SB_DEPTH + 1),
  localparam int LCNT_W  = $clog2(MAX_LOADS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [2:0]         inOp,
  input  logic               memReqReady,
  input  logic               memRspValid,
  input  logic               memRspWrite,
  input  logic [QCNT_W-1:0]  qCount,
  input  logic [SBCNT_W-1:0] sbCount,
  input  logic [2:0]         headOp,
  input  logic               matchHit,
  output fseqStrb_t          strb,
  output logic               inReady,
  output logic               busy,
  output logic               memReqValid,
  output logic               memReqWrite,
  output logic [LCNT_W-1:0]  loadCnt,
  output logic               storeInFlight
);

  logic serPending;
  logic headValid, nonMem, barrierMet;
  logic loadWant, storeWant, issueLoad, issueStore, sbPush, retire, qPush;

  assign headValid = (qCount != '0);

  always_comb begin
    nonMem     = 1'b1;
    barrierMet = 1'b1;
    case (headOp)
      OP_LOAD, OP_STORE: begin
        nonMem     = 1'b0;
        barrierMet = 1'b0;
      end
      OP_LFENCE: barrierMet = (loadCnt == '0);
      OP_SFENCE: barrierMet = 1'b1;
      OP_FULL, OP_SERIAL:
        barrierMet = (loadCnt == '0) && (sbCount == '0) && !storeInFlight;
      default:   barrierMet = 1'b1;
    endcase
  end

  assign retire    = headValid && nonMem && barrierMet && !memRspValid;
  assign loadWant  = headValid && (headOp == OP_LOAD) && !matchHit &&
                     (loadCnt < LCNT_W'(MAX_LOADS));
  assign storeWant = (sbCount != '0) && !storeInFlight;
  assign issueLoad  = loadWant && memReqReady;
  assign issueStore = !loadWant && storeWant && memReqReady;
  assign sbPush    = headValid && (headOp == OP_STORE) &&
                     (sbCount < SBCNT_W'(SB_DEPTH));

  assign inReady = (qCount < QCNT_W'(Q_DEPTH)) && !serPending;
  assign qPush   = inValid && inReady;
  assign busy    = serPending;

  assign memReqValid = loadWant || storeWant;
  assign memReqWrite = !loadWant;

  always_comb begin
    strb            = '0;
    strb.qPush      = qPush;
    strb.qPop       = issueLoad || sbPush || retire;
    strb.sbPush     = sbPush;
    strb.sbPop      = issueStore;
    strb.selStore   = !loadWant;
    strb.retireHead = retire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loadCnt       <= '0;
      storeInFlight <= 1'b0;
      serPending    <= 1'b0;
    end else begin
      case ({issueLoad, memRspValid && !memRspWrite})
        2'b10:   loadCnt <= loadCnt + 1'b1;
        2'b01:   loadCnt <= loadCnt - 1'b1;
        default: ;
      endcase
      if (issueStore) storeInFlight <= 1'b1;
      else if (memRspValid && memRspWrite) storeInFlight <= 1'b0;
      if (qPush && (inOp == OP_SERIAL)) serPending <= 1'b1;
      else if (retire && (headOp == OP_SERIAL)) serPending <= 1'b0;
    end
  end

endmodule

// File: rtl/fence_seq.sv
module fence_seq
  import fseq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int TAG_W     = 4,
  parameter int Q_DEPTH   = 8,
  parameter int SB_DEPTH  = 4,
  parameter int MAX_LOADS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [2:0]        inOp,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  input  logic [TAG_W-1:0]  inTag,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqData,
  output logic [TAG_W-1:0]  memReqTag,
  input  logic              memRspValid,
  input  logic              memRspWrite,
  input  logic [TAG_W-1:0]  memRspTag,
  input  logic [DATA_W-1:0] memRspData,
  output logic              doneValid,
  output logic [TAG_W-1:0]  doneTag,
  output logic [DATA_W-1:0] doneData,
  output logic              busy
);

  localparam int QCNT_W  = $clog2(Q_DEPTH + 1);
  localparam int SBCNT_W = $clog2(SB_DEPTH + 1);
  localparam int LCNT_W  = $clog2(MAX_LOADS + 1);

  fseqStrb_t          strb;
  logic [QCNT_W-1:0]  qCount;
  logic [SBCNT_W-1:0] sbCount;
  logic [2:0]         headOp;
  logic               matchHit;
  logic [LCNT_W-1:0]  loadCnt;
  logic               storeInFlight;

  fseq_ctrl #(
    .Q_DEPTH(Q_DEPTH), .SB_DEPTH(SB_DEPTH), .MAX_LOADS(MAX_LOADS)
  ) uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inOp(inOp),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .memRspWrite(memRspWrite), .qCount(qCount), .sbCount(sbCount),
    .headOp(headOp), .matchHit(matchHit), .strb(strb), .inReady(inReady),
    .busy(busy), .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .loadCnt(loadCnt), .storeInFlight(storeInFlight)
  );

  fseq_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W),
    .Q_DEPTH(Q_DEPTH), .SB_DEPTH(SB_DEPTH)
  ) uData (
    .clk(clk), .rst(rst), .strb(strb), .inOp(inOp), .inAddr(inAddr),
    .inData(inData), .inTag(inTag), .flightValid(storeInFlight),
    .memRspValid(memRspValid), .memRspWrite(memRspWrite),
    .memRspTag(memRspTag), .memRspData(memRspData), .qCount(qCount),
    .sbCount(sbCount), .headOp(headOp), .matchHit(matchHit),
    .memReqAddr(memReqAddr), .memReqData(memReqData), .memReqTag(memReqTag),
    .doneValid(doneValid), .doneTag(doneTag), .doneData(doneData)
  );

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
  parameter int TAG_W     = 4,
  parameter int DATA_W    = 32,
  parameter int MAX_LOADS = 4,
  parameter int LCNT_W    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              inReady,
  input logic              busy,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic              memRspValid,
  input logic              memRspWrite,
  input logic [TAG_W-1:0]  memRspTag,
  input logic [DATA_W-1:0] memRspData,
  input logic              doneValid,
  input logic [TAG_W-1:0]  doneTag,
  input logic [DATA_W-1:0] doneData,
  input logic [LCNT_W-1:0] loadCnt
);

  assert_serial_blocks_intake_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !inReady);

  assert_serial_release_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(doneValid && !memRspValid));

  assert_single_write_R3: assert property (@(posedge clk) disable iff (rst)
    (memReqValid && memReqReady && memReqWrite) |=> !(memReqValid && memReqWrite));

  assert_load_cap_R2: assert property (@(posedge clk) disable iff (rst)
    loadCnt <= LCNT_W'(MAX_LOADS));

  assert_load_data_R2: assert property (@(posedge clk) disable iff (rst)
    (memRspValid && !memRspWrite) |-> (doneValid && doneTag == memRspTag && doneData == memRspData));

  assert_response_owns_done_R10: assert property (@(posedge clk) disable iff (rst)
    (memRspValid && memRspWrite) |-> (doneValid && doneTag == memRspTag));

  assert_barrier_no_read_R10: assert property (@(posedge clk) disable iff (rst)
    (doneValid && !memRspValid) |-> !(memReqValid && !memReqWrite));

endmodule

bind fence_seq fseq_chk #(
  .TAG_W(TAG_W), .DATA_W(DATA_W), .MAX_LOADS(MAX_LOADS), .LCNT_W(LCNT_W)
) uChk (
  .clk(clk), .rst(rst), .inReady(inReady), .busy(busy),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
  .memRspValid(memRspValid), .memRspWrite(memRspWrite), .memRspTag(memRspTag),
  .memRspData(memRspData), .doneValid(doneValid), .doneTag(doneTag),
  .doneData(doneData), .loadCnt(loadCnt)
);

// File: tb/sim_fence_seq.sv
module sim_fence_seq;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst;
  logic        inValid, inReady;
  logic [2:0]  inOp;
  logic [7:0]  inAddr;
  logic [31:0] inData;
  logic [3:0]  inTag;
  logic        memReqValid, memReqReady, memReqWrite;
  logic [7:0]  memReqAddr;
  logic [31:0] memReqData;
  logic [3:0]  memReqTag;
  logic        memRspValid, memRspWrite;
  logic [3:0]  memRspTag;
  logic [31:0] memRspData;
  logic        doneValid;
  logic [3:0]  doneTag;
  logic [31:0] doneData;
  logic        busy;

  fence_seq u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inOp(inOp),
    .inAddr(inAddr), .inData(inData), .inTag(inTag),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqData(memReqData), .memReqTag(memReqTag),
    .memRspValid(memRspValid), .memRspWrite(memRspWrite), .memRspTag(memRspTag),
    .memRspData(memRspData), .doneValid(doneValid), .doneTag(doneTag),
    .doneData(doneData), .busy(busy)
  );

  int cycle = 0;
  always @(posedge clk) cycle++;

  int nChecks = 0;
  int nErr = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // memory model: addresses 8..15 slow, others fast
  logic [31:0] mem [16];
  logic [31:0] shadow [16];
  int reqCyc [16];
  int doneCyc [16];
  int acceptCyc [16];

  typedef struct {
    bit          v;
    bit          w;
    logic [3:0]  tag;
    logic [7:0]  addr;
    logic [31:0] data;
    int          due;
  } pend_t;
  pend_t pend [16];

  function automatic int latFor(input logic [7:0] a);
    return a[3] ? 15 : 2;
  endfunction

  always @(negedge clk) begin
    if (!rst && memReqValid && memReqReady) begin
      reqCyc[memReqTag] = cycle;
      for (int i = 0; i < 16; i++) begin
        if (!pend[i].v) begin
          pend[i] = '{1'b1, memReqWrite, memReqTag, memReqAddr, memReqData,
                      cycle + latFor(memReqAddr)};
          break;
        end
      end
    end
  end

  initial begin
    memRspValid = 1'b0;
    memRspWrite = 1'b0;
    memRspTag   = '0;
    memRspData  = '0;
    forever begin
      int best;
      @(posedge clk);
      #1;
      memRspValid = 1'b0;
      memRspData  = '0;
      best = -1;
      for (int i = 0; i < 16; i++)
        if (pend[i].v && pend[i].due <= cycle &&
            (best < 0 || pend[i].due < pend[best].due)) best = i;
      if (best >= 0) begin
        memRspValid = 1'b1;
        memRspWrite = pend[best].w;
        memRspTag   = pend[best].tag;
        if (pend[best].w) mem[pend[best].addr[3:0]] = pend[best].data;
        else memRspData = mem[pend[best].addr[3:0]];
        pend[best].v = 1'b0;
      end
    end
  end

  // scoreboard
  typedef struct {
    logic [3:0]  tag;
    bit          isLoad;
    logic [31:0] data;
  } exp_t;
  exp_t expQ[$];
  int busyOpen = 0;

  always @(negedge clk) begin
    int idx;
    if (!rst) begin
      if (busy && inReady) busyOpen++;
      if (doneValid) begin
        doneCyc[doneTag] = cycle;
        idx = -1;
        foreach (expQ[i]) if (idx < 0 && expQ[i].tag == doneTag) idx = i;
        check(idx >= 0, "R10", "done for a tag not in flight", doneTag, -1);
        if (idx >= 0) begin
          if (expQ[idx].isLoad)
            check(doneData == expQ[idx].data, "R2", "load data", doneData, expQ[idx].data);
          expQ.delete(idx);
        end
      end
    end
  end

  // driver: call just after a rising edge, returns just after a rising edge
  task automatic sendOp(input logic [2:0] op, input logic [7:0] addr,
                        input logic [31:0] data, input logic [3:0] tag);
    exp_t e;
    e.tag    = tag;
    e.isLoad = (op == 3'd0);
    e.data   = (op == 3'd0) ? shadow[addr[3:0]] : 32'd0;
    if (op == 3'd1) shadow[addr[3:0]] = data;
    expQ.push_back(e);
    reqCyc[tag]  = -1;
    doneCyc[tag] = -1;
    inValid = 1'b1;
    inOp    = op;
    inAddr  = addr;
    inData  = data;
    inTag   = tag;
    forever begin
      @(negedge clk);
      if (inReady) begin
        acceptCyc[tag] = cycle;
        break;
      end
      @(posedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    inValid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (expQ.size() != 0 && n < 2000) begin
      @(posedge clk);
      n++;
    end
    check(expQ.size() == 0, "R2", "operations left unretired", expQ.size(), 0);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nErr++;
    nChecks++;
    $display("FAIL R1 watchdog expired actual=%0d expected=finish", cycle);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i]    = 32'h100 + i;
      shadow[i] = 32'h100 + i;
      pend[i].v = 1'b0;
      reqCyc[i] = -1;
      doneCyc[i] = -1;
      acceptCyc[i] = -1;
    end
    rst = 1'b1;
    inValid = 1'b0;
    inOp = '0;
    inAddr = '0;
    inData = '0;
    inTag = '0;
    memReqReady = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    check(inReady == 1'b1, "R1", "inReady after reset", inReady, 1);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(doneValid == 1'b0, "R1", "doneValid after reset", doneValid, 0);
    check(memReqValid == 1'b0, "R1", "memReqValid after reset", memReqValid, 0);
    @(posedge clk);
    #1;

    // R4: load to a different address overtakes a slow buffered store
    sendOp(3'd1, 8'd9, 32'hA001, 4'd1);
    sendOp(3'd0, 8'd2, 32'd0, 4'd2);
    drain();
    check(reqCyc[2] < reqCyc[1], "R4", "load request before store request", reqCyc[2], reqCyc[1]);
    check(doneCyc[2] < doneCyc[1], "R4", "load done before store done", doneCyc[2], doneCyc[1]);

    // R5: load to the address of a buffered store waits for the write
    sendOp(3'd1, 8'd3, 32'hB003, 4'd1);
    sendOp(3'd0, 8'd3, 32'd0, 4'd2);
    drain();
    check(reqCyc[2] > doneCyc[1], "R5", "load request after matching write response", reqCyc[2], doneCyc[1] + 1);

    // R2: reads overlap
    sendOp(3'd0, 8'd13, 32'd0, 4'd1);
    sendOp(3'd0, 8'd14, 32'd0, 4'd2);
    drain();
    check(reqCyc[2] < doneCyc[1], "R2", "second read issued while first outstanding", reqCyc[2], doneCyc[1]);

    // R6: load fence
    sendOp(3'd0, 8'd12, 32'd0, 4'd1);
    sendOp(3'd2, 8'd0, 32'd0, 4'd2);
    sendOp(3'd0, 8'd4, 32'd0, 4'd3);
    drain();
    check(doneCyc[2] > doneCyc[1], "R6", "load fence retires after older load", doneCyc[2], doneCyc[1] + 1);
    check(reqCyc[3] > doneCyc[1], "R6", "younger load requested after older load done", reqCyc[3], doneCyc[1] + 1);
    check(reqCyc[2] == -1, "R10", "load fence made a request", reqCyc[2], -1);

    // R7: store fence lets a load finish before an older store
    sendOp(3'd1, 8'd9, 32'hC009, 4'd1);
    sendOp(3'd3, 8'd0, 32'd0, 4'd2);
    sendOp(3'd0, 8'd2, 32'd0, 4'd3);
    drain();
    check(doneCyc[2] < doneCyc[1], "R7", "store fence retires before older store", doneCyc[2], doneCyc[1]);
    check(doneCyc[3] < doneCyc[1], "R7", "load behind store fence done before older store", doneCyc[3], doneCyc[1]);

    // R8: full fence
    sendOp(3'd1, 8'd10, 32'hD00A, 4'd4);
    sendOp(3'd4, 8'd0, 32'd0, 4'd5);
    sendOp(3'd0, 8'd2, 32'd0, 4'd6);
    drain();
    check(doneCyc[5] > doneCyc[4], "R8", "full fence retires after older store", doneCyc[5], doneCyc[4] + 1);
    check(reqCyc[6] > doneCyc[4], "R8", "load behind full fence waits", reqCyc[6], doneCyc[4] + 1);
    check(acceptCyc[6] < doneCyc[5], "R8", "intake open while full fence waits", acceptCyc[6], doneCyc[5]);
    check(reqCyc[5] == -1, "R10", "full fence made a request", reqCyc[5], -1);

    // R9: serialize
    sendOp(3'd1, 8'd11, 32'hE00B, 4'd7);
    sendOp(3'd5, 8'd0, 32'd0, 4'd8);
    @(negedge clk);
    check(busy == 1'b1, "R9", "busy while serialize waits", busy, 1);
    check(inReady == 1'b0, "R9", "inReady while serialize waits", inReady, 0);
    @(posedge clk);
    #1;
    sendOp(3'd0, 8'd1, 32'd0, 4'd9);
    drain();
    check(doneCyc[8] > doneCyc[7], "R9", "serialize retires after older store", doneCyc[8], doneCyc[7] + 1);
    check(acceptCyc[9] > doneCyc[8], "R9", "next op accepted after serialize", acceptCyc[9], doneCyc[8] + 1);
    check(busyOpen == 0, "R9", "cycles with busy and inReady both high", busyOpen, 0);
    @(negedge clk);
    check(busy == 1'b0 && inReady == 1'b1, "R9", "intake reopened", {busy, inReady}, 1);
    @(posedge clk);
    #1;

    // R3: six slow stores fill the buffer and write in order, then R5 readback
    for (int k = 1; k <= 6; k++)
      sendOp(3'd1, 8'(7 + k), 32'hF000 + k, 4'(k));
    sendOp(3'd0, 8'd13, 32'd0, 4'd7);
    drain();
    for (int k = 1; k <= 5; k++)
      check(reqCyc[k + 1] > doneCyc[k], "R3", "write issued after previous write response",
            reqCyc[k + 1], doneCyc[k] + 1);
    check(reqCyc[7] > doneCyc[6], "R5", "readback after last matching write", reqCyc[7], doneCyc[6] + 1);

    // R10: no-op codes
    sendOp(3'd6, 8'd0, 32'd0, 4'd10);
    sendOp(3'd7, 8'd0, 32'd0, 4'd11);
    drain();
    check(doneCyc[10] >= 0 && reqCyc[10] == -1, "R10", "no-op 6 retired without request", reqCyc[10], -1);
    check(doneCyc[11] > doneCyc[10] && reqCyc[11] == -1, "R10", "no-op 7 retired in order", doneCyc[11], doneCyc[10] + 1);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule